// File: doc/BRIEF.md
# Four-Way Set-Associative Translation Buffer

This block holds recently used address translations for a 32-bit virtual address space divided into 4 KB pages. A lookup presents a full virtual address; the block selects one of sixteen sets from the low bits of the virtual page number and compares the remaining bits against the four ways of that set in the same cycle. On a hit it returns the physical address, formed from the frame number held in the cached entry and the untouched page offset. It also reports whether the hit entry came from the directory level or the table level.

A page walker installs translations through a fill port. A fill whose tag already sits in the target set rewrites that way. Otherwise the fill takes the lowest-numbered empty way. When every way is occupied, it evicts the way named by a per-set rotating pointer. Two flush inputs empty the buffer: one removes everything, and the other, used on a task switch, removes only entries whose global bit is clear. Each flush completes in one clock.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports `lk_hit` = 0, `lk_paddr` = 0 and `lk_dir` = 0.
- R2: A lookup uses `lk_vaddr[31:16]` as tag and `lk_vaddr[15:12]` as set index. It hits when a valid way of that set holds the same tag, and `lk_paddr[31:12]` is then bits 31:12 of the stored entry. On a miss `lk_paddr` is 0.
- R3: On a hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]`.
- R4: On a hit `lk_dir` repeats the directory flag stored with the entry (1 = directory level, 0 = table level).
- R5: A fill whose tag is not present in its set writes the lowest-numbered invalid way of that set when one exists, leaving the rotating pointer unchanged.
- R6: When all four ways of a set are valid and the tag is absent, the fill replaces the way named by that set's pointer. The pointer starts at 0 after reset and advances by one, modulo 4, after each such replacement.
- R7: A fill whose tag is already valid in its set rewrites that way, never creates a second copy, and leaves the pointer unchanged.
- R8: A lookup reports a miss in any cycle where `fill_en` is high and `fill_vpn[3:0]` equals the lookup's set index. Lookups into other sets are unaffected.
- R9: A cycle with `flush_all` high leaves every entry invalid from the next cycle on.
- R10: A cycle with `flush_task` high invalidates every entry whose stored bit 8 is 0 and keeps every entry whose bit 8 is 1, effective the next cycle.
- R11: `flush_all` takes priority over `flush_task`. A fill presented in the same cycle as either flush is discarded.
- R12: Sets are independent: the same tag may be valid in several sets at once, each with its own entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found this cycle |
| lk_paddr | output | 32 | Physical address on hit, 0 on miss |
| lk_dir | output | 1 | Hit entry is a directory-level entry |
| fill_en | input | 1 | Install a translation at the next edge |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_dir | input | 1 | Directory/table flag of the fill |
| fill_data | input | 32 | Entry word to store; bits 31:12 frame number, bit 8 global |
| flush_all | input | 1 | Invalidate every entry |
| flush_task | input | 1 | Invalidate every non-global entry |

## Verification
Every cycle, the assertions check that no set ever holds two valid copies of a tag. They also check that a hit always passes the page offset through, that a miss yields a zero address, and that a full flush leaves no hit in the next cycle. For each of the 64 entries, they check that a task flush keeps it when global and drops it otherwise. Only the bench scenarios can show which way a fill chooses. The bench infers that choice from which earlier translation stops hitting. Its scenarios cover the order of free-way use, the pointer's rotation, in-place rewrite, the lookup block during a same-set fill, and the flush priorities.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    parameter int VPN_W   = 20;
    parameter int OFF_W   = 12;
    parameter int SET_W   = 4;
    parameter int WAY_N   = 4;
    parameter int DATA_W  = 32;
    parameter int GLB_BIT = 8;

    parameter int SET_N = 1 << SET_W;
    parameter int TAG_W = VPN_W - SET_W;
    parameter int WAY_W = $clog2(WAY_N);
    parameter int VA_W  = VPN_W + OFF_W;
    parameter int PPN_W = VA_W - OFF_W;

    typedef struct packed {
        logic              vld;
        logic              dir;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef struct packed {
        entry_t [SET_N-1:0][WAY_N-1:0] ent;
        logic   [SET_N-1:0][WAY_W-1:0] rr;
    } state_t;

    function automatic logic [WAY_W-1:0] low_idx(input logic [WAY_N-1:0] v);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int i = WAY_N - 1; i >= 0; i--) begin
            if (v[i]) r = WAY_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
(
    input  entry_t [WAY_N-1:0] ways_i,
    input  logic   [TAG_W-1:0] tag_i,
    output logic   [WAY_N-1:0] hit_vec_o,
    output logic               hit_o
);
    for (genvar w = 0; w < WAY_N; w++) begin : g_way
        assign hit_vec_o[w] = ways_i[w].vld && (ways_i[w].tag == tag_i);
    end

    assign hit_o = |hit_vec_o;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
(
    input  logic [WAY_N-1:0] vld_vec_i,
    input  logic [WAY_N-1:0] hit_vec_i,
    input  logic [WAY_W-1:0] rr_i,
    output logic [WAY_W-1:0] sel_o,
    output logic             evict_o
);
    logic [WAY_N-1:0] free_vec;

    assign free_vec = ~vld_vec_i;

    always_comb begin
        sel_o   = rr_i;
        evict_o = 1'b0;
        if (|hit_vec_i) begin
            sel_o = low_idx(hit_vec_i);
        end else if (|free_vec) begin
            sel_o = low_idx(free_vec);
        end else begin
            evict_o = 1'b1;
        end
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic [VA_W-1:0]   lk_paddr,
    output logic              lk_dir,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic              fill_dir,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              flush_all,
    input  logic              flush_task
);
    state_t st_d, st_q;

    // lookup side
    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [WAY_N-1:0] lk_hit_vec;
    logic             lk_any;
    logic             lk_block;
    entry_t           lk_ent;

    // fill side
    logic [SET_W-1:0] fl_set;
    logic [TAG_W-1:0] fl_tag;
    logic [WAY_N-1:0] fl_hit_vec;
    logic             fl_any;
    logic [WAY_N-1:0] fl_vld_vec;
    logic [WAY_W-1:0] fl_sel;
    logic             fl_evict;

    assign lk_set = lk_vaddr[OFF_W +: SET_W];
    assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
    assign fl_set = fill_vpn[SET_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1 -: TAG_W];

    xlat_match u_lk_match (
        .ways_i    (st_q.ent[lk_set]),
        .tag_i     (lk_tag),
        .hit_vec_o (lk_hit_vec),
        .hit_o     (lk_any)
    );

    xlat_match u_fl_match (
        .ways_i    (st_q.ent[fl_set]),
        .tag_i     (fl_tag),
        .hit_vec_o (fl_hit_vec),
        .hit_o     (fl_any)
    );

    for (genvar w = 0; w < WAY_N; w++) begin : g_vld
        assign fl_vld_vec[w] = st_q.ent[fl_set][w].vld;
    end

    xlat_victim u_victim (
        .vld_vec_i (fl_vld_vec),
        .hit_vec_i (fl_hit_vec),
        .rr_i      (st_q.rr[fl_set]),
        .sel_o     (fl_sel),
        .evict_o   (fl_evict)
    );

    // a same-set fill masks the lookup for the cycle
    assign lk_block = fill_en && (fl_set == lk_set);
    assign lk_ent   = st_q.ent[lk_set][low_idx(lk_hit_vec)];
    assign lk_hit   = lk_any && !lk_block;
    assign lk_paddr = lk_hit ? {lk_ent.data[DATA_W-1 -: PPN_W], lk_vaddr[OFF_W-1:0]} : '0;
    assign lk_dir   = lk_hit && lk_ent.dir;

    always_comb begin
        st_d = st_q;
        if (flush_all) begin
            for (int s = 0; s < SET_N; s++) begin
                for (int w = 0; w < WAY_N; w++) begin
                    st_d.ent[s][w].vld = 1'b0;
                end
            end
        end else if (flush_task) begin
            for (int s = 0; s < SET_N; s++) begin
                for (int w = 0; w < WAY_N; w++) begin
                    if (!st_q.ent[s][w].data[GLB_BIT]) st_d.ent[s][w].vld = 1'b0;
                end
            end
        end else if (fill_en) begin
            st_d.ent[fl_set][fl_sel].vld  = 1'b1;
            st_d.ent[fl_set][fl_sel].dir  = fill_dir;
            st_d.ent[fl_set][fl_sel].tag  = fl_tag;
            st_d.ent[fl_set][fl_sel].data = fill_data;
            if (fl_evict && !fl_any) st_d.rr[fl_set] = st_q.rr[fl_set] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_hit,
    input logic [VA_W-1:0]  lk_paddr,
    input logic             flush_all,
    input logic             flush_task,
    input logic [WAY_N-1:0] lk_hit_vec,
    input state_t           st_q
);
    AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec)) else $error("duplicate tag in set"); // R7

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0])) else $error("offset altered"); // R3

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0)) else $error("miss with nonzero address"); // R2

    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !lk_hit) else $error("hit after full flush"); // R9

    for (genvar s = 0; s < SET_N; s++) begin : g_set
        for (genvar w = 0; w < WAY_N; w++) begin : g_way
            AST_TASK_KEEP_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
                (flush_task && !flush_all && st_q.ent[s][w].vld && st_q.ent[s][w].data[GLB_BIT])
                |=> st_q.ent[s][w].vld) else $error("global entry lost"); // R10

            AST_TASK_DROP_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
                (flush_task && !st_q.ent[s][w].data[GLB_BIT])
                |=> !st_q.ent[s][w].vld) else $error("local entry kept"); // R10
        end
    end
endmodule

bind xlat_cache xlat_cache_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_vaddr   (lk_vaddr),
    .lk_hit     (lk_hit),
    .lk_paddr   (lk_paddr),
    .flush_all  (flush_all),
    .flush_task (flush_task),
    .lk_hit_vec (lk_hit_vec),
    .st_q       (st_q)
);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        lk_dir;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic        fill_dir = 1'b0;
    logic [31:0] fill_data = '0;
    logic        flush_all = 1'b0;
    logic        flush_task = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    xlat_cache uut (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
        .lk_paddr(lk_paddr), .lk_dir(lk_dir), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_dir(fill_dir), .fill_data(fill_data),
        .flush_all(flush_all), .flush_task(flush_task)
    );

    function automatic logic [31:0] va(input logic [15:0] t, input logic [3:0] s, input logic [11:0] o);
        return {t, s, o};
    endfunction

    function automatic logic [31:0] ent(input logic [19:0] ppn, input logic g);
        return {ppn, 3'b000, g, 8'h01};
    endfunction

    task automatic compare(input string rq, input logic h, input logic [31:0] pa, input logic d,
                           input logic eh, input logic [31:0] epa, input logic ed);
        checks++;
        if (h !== eh || pa !== epa || d !== ed) begin
            errors++;
            $display("FAIL %s: hit=%0b pa=%h dir=%0b expected hit=%0b pa=%h dir=%0b",
                     rq, h, pa, d, eh, epa, ed);
        end
    endtask

    task automatic expect_lk(input string rq, input logic [31:0] a, input logic eh,
                             input logic [19:0] eppn, input logic ed);
        @(negedge clk);
        lk_vaddr = a;
        #1;
        compare(rq, lk_hit, lk_paddr, lk_dir, eh, eh ? {eppn, a[11:0]} : 32'h0, eh ? ed : 1'b0);
    endtask

    task automatic fill(input logic [15:0] t, input logic [3:0] s, input logic d, input logic [31:0] e);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = {t, s}; fill_dir = d; fill_data = e;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic flush(input logic all, input logic tsk);
        @(negedge clk);
        flush_all = all; flush_task = tsk;
        @(negedge clk);
        flush_all = 1'b0; flush_task = 1'b0;
    endtask

    task automatic t_reset;
        expect_lk("R1", va(16'h1234, 4'd3, 12'h000), 1'b0, 20'h0, 1'b0);
        expect_lk("R1", va(16'h0000, 4'd0, 12'hFFF), 1'b0, 20'h0, 1'b0);
    endtask

    task automatic t_basic;
        fill(16'hAAAA, 4'd1, 1'b0, ent(20'h12345, 1'b0));
        fill(16'hBBBB, 4'd1, 1'b1, ent(20'h0F0F0, 1'b0));
        expect_lk("R2 R3", va(16'hAAAA, 4'd1, 12'hABC), 1'b1, 20'h12345, 1'b0);
        expect_lk("R4",    va(16'hBBBB, 4'd1, 12'h001), 1'b1, 20'h0F0F0, 1'b1);
        expect_lk("R2",    va(16'hAAAB, 4'd1, 12'h000), 1'b0, 20'h0, 1'b0);
        expect_lk("R2",    va(16'hAAAA, 4'd2, 12'h000), 1'b0, 20'h0, 1'b0);
    endtask

    task automatic t_sets;
        fill(16'h7777, 4'd2, 1'b0, ent(20'h00001, 1'b0));
        fill(16'h7777, 4'd4, 1'b0, ent(20'h00002, 1'b0));
        expect_lk("R12", va(16'h7777, 4'd2, 12'h010), 1'b1, 20'h00001, 1'b0);
        expect_lk("R12", va(16'h7777, 4'd4, 12'h020), 1'b1, 20'h00002, 1'b0);
    endtask

    task automatic t_rotate;
        for (int i = 0; i < 4; i++) fill(16'h0500 + 16'(i), 4'd5, 1'b0, ent(20'h05000 + 20'(i), 1'b0));
        fill(16'h0504, 4'd5, 1'b0, ent(20'h05004, 1'b0));
        expect_lk("R6", va(16'h0500, 4'd5, 12'h0), 1'b0, 20'h0, 1'b0);
        expect_lk("R6", va(16'h0504, 4'd5, 12'h0), 1'b1, 20'h05004, 1'b0);
        expect_lk("R6", va(16'h0501, 4'd5, 12'h0), 1'b1, 20'h05001, 1'b0);
        fill(16'h0502, 4'd5, 1'b1, ent(20'h05F02, 1'b0));
        expect_lk("R7", va(16'h0502, 4'd5, 12'h3), 1'b1, 20'h05F02, 1'b1);
        fill(16'h0505, 4'd5, 1'b0, ent(20'h05005, 1'b0));
        expect_lk("R7 R6", va(16'h0501, 4'd5, 12'h0), 1'b0, 20'h0, 1'b0);
        expect_lk("R7", va(16'h0502, 4'd5, 12'h0), 1'b1, 20'h05F02, 1'b1);
        expect_lk("R6", va(16'h0503, 4'd5, 12'h0), 1'b1, 20'h05003, 1'b0);
        expect_lk("R6", va(16'h0504, 4'd5, 12'h0), 1'b1, 20'h05004, 1'b0);
        expect_lk("R6", va(16'h0505, 4'd5, 12'h0), 1'b1, 20'h05005, 1'b0);
    endtask

    task automatic t_free_ways;
        fill(16'h0700, 4'd7, 1'b0, ent(20'h07000, 1'b1));
        fill(16'h0701, 4'd7, 1'b0, ent(20'h07001, 1'b0));
        fill(16'h0702, 4'd7, 1'b0, ent(20'h07002, 1'b1));
        flush(1'b0, 1'b1);
        expect_lk("R10", va(16'h0701, 4'd7, 12'h0), 1'b0, 20'h0, 1'b0);
        expect_lk("R10", va(16'h0700, 4'd7, 12'h0), 1'b1, 20'h07000, 1'b0);
        expect_lk("R10", va(16'h0702, 4'd7, 12'h0), 1'b1, 20'h07002, 1'b0);
        expect_lk("R10", va(16'hBBBB, 4'd1, 12'h0), 1'b0, 20'h0, 1'b0);
        fill(16'h0703, 4'd7, 1'b0, ent(20'h07003, 1'b0));
        fill(16'h0704, 4'd7, 1'b0, ent(20'h07004, 1'b0));
        fill(16'h0705, 4'd7, 1'b0, ent(20'h07005, 1'b0));
        expect_lk("R5", va(16'h0700, 4'd7, 12'h0), 1'b0, 20'h0, 1'b0);
        expect_lk("R5", va(16'h0702, 4'd7, 12'h0), 1'b1, 20'h07002, 1'b0);
        expect_lk("R5", va(16'h0703, 4'd7, 12'h0), 1'b1, 20'h07003, 1'b0);
        expect_lk("R5", va(16'h0704, 4'd7, 12'h0), 1'b1, 20'h07004, 1'b0);
        expect_lk("R5", va(16'h0705, 4'd7, 12'h0), 1'b1, 20'h07005, 1'b0);
    endtask

    task automatic t_block;
        fill(16'h0900, 4'd9, 1'b0, ent(20'h09000, 1'b1));
        fill(16'h0A00, 4'd10, 1'b0, ent(20'h0A000, 1'b1));
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = {16'h0901, 4'd9}; fill_dir = 1'b0; fill_data = ent(20'h09001, 1'b1);
        lk_vaddr = va(16'h0900, 4'd9, 12'h0);
        #1;
        compare("R8", lk_hit, lk_paddr, lk_dir, 1'b0, 32'h0, 1'b0);
        lk_vaddr = va(16'h0A00, 4'd10, 12'h044);
        #1;
        compare("R8", lk_hit, lk_paddr, lk_dir, 1'b1, {20'h0A000, 12'h044}, 1'b0);
        @(negedge clk);
        fill_en = 1'b0;
        expect_lk("R8", va(16'h0900, 4'd9, 12'h0), 1'b1, 20'h09000, 1'b0);
        expect_lk("R8", va(16'h0901, 4'd9, 12'h0), 1'b1, 20'h09001, 1'b0);
    endtask

    task automatic t_flush_prio;
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = {16'h0B00, 4'd11}; fill_data = ent(20'h0B000, 1'b1); flush_all = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; flush_all = 1'b0;
        expect_lk("R11", va(16'h0B00, 4'd11, 12'h0), 1'b0, 20'h0, 1'b0);
        fill(16'h0D00, 4'd13, 1'b0, ent(20'h0D000, 1'b1));
        flush(1'b1, 1'b1);
        expect_lk("R11", va(16'h0D00, 4'd13, 12'h0), 1'b0, 20'h0, 1'b0);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = {16'h0E00, 4'd14}; fill_data = ent(20'h0E000, 1'b1); flush_task = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; flush_task = 1'b0;
        expect_lk("R11", va(16'h0E00, 4'd14, 12'h0), 1'b0, 20'h0, 1'b0);
    endtask

    task automatic t_flush_all;
        fill(16'h0C00, 4'd12, 1'b0, ent(20'h0C000, 1'b1));
        fill(16'h0C01, 4'd0, 1'b1, ent(20'h0C001, 1'b0));
        expect_lk("R9", va(16'h0C00, 4'd12, 12'h0), 1'b1, 20'h0C000, 1'b0);
        flush(1'b1, 1'b0);
        expect_lk("R9", va(16'h0C00, 4'd12, 12'h0), 1'b0, 20'h0, 1'b0);
        expect_lk("R9", va(16'h0C01, 4'd0, 12'h0), 1'b0, 20'h0, 1'b0);
        expect_lk("R9", va(16'h0A00, 4'd10, 12'h0), 1'b0, 20'h0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_sets();
        t_rotate();
        t_free_ways();
        t_block();
        t_flush_prio();
        t_flush_all();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule